// File: doc/BRIEF.md
# Hierarchical Bus Enumeration Walker

This block discovers every function on a tree of configuration buses that bridges join together. After a start pulse it probes the root bus (bus 0) one device and function at a time, through a single configuration read/write port that allows one request in flight. A probe that returns all ones means no function sits at that slot. For each function that answers, the walker reads its header type and class code and sends one result beat on a valid/ready stream. The beat carries bus, device, function, vendor identifier and header type byte.

The scan is depth-first. When a result describes a bridge to another configuration bus, the walker writes the next free bus number into that bridge. It saves its place on an internal stack and scans the new bus completely. After that it resumes the parent bus just after the bridge. Bus numbers go out in strictly increasing order of discovery. When the whole tree has been walked, a one-cycle done pulse appears together with the count of bus numbers handed to bridges. If the tree is deeper than the stack, the walker still reports the bridge that would overflow the stack, but skips the subtree behind it and raises a sticky error flag.

Top module: `bus_enum_walker`

## Requirements
- R1: After reset, cfg_req_valid, res_valid, done and stack_err are all 0, and nothing moves until start is seen while idle.
- R2: The first request after start is a read of dword index 0 (identifier dword) at bus 0, device 0, function 0. Every read targets a bus number that has already been assigned.
- R3: A read of dword 0 that returns 32'hFFFFFFFF marks the slot absent and produces no result beat. If the absent slot is function 0, the remaining functions of that device are not probed.
- R4: The header type byte is bits [23:16] of dword 3. Functions 1 to 7 of a device are probed only when bit 7 of function 0's header type byte is 1. Otherwise the walker moves on to the next device after function 0.
- R5: Each present function yields exactly one result beat with its bus, device, function, vendor (bits [15:0] of dword 0) and the full header type byte. Beats follow depth-first discovery order, and a beat is held unchanged while res_ready is 0.
- R6: A function is a bridge when header type bits [6:0] equal 1 and the class code (bits [31:8] of dword 2) equals 24'h060400. For a bridge, after its result beat the walker writes dword 6 of that function with {8'h00, 8'hFF, new secondary bus, current bus} in bits [31:24], [23:16], [15:8], [7:0]. It then scans the secondary bus fully before it probes the next slot of the parent bus.
- R7: Bridges receive bus numbers 1, 2, 3, ... in the order in which they are discovered.
- R8: A function with header type 2, or with header type 1 but a class code other than 24'h060400, is reported and not descended into, and no write is issued for it.
- R9: With STACK_DEPTH levels already saved, a further bridge is reported but gets no write and no bus number, its subtree is skipped, and stack_err rises and stays 1 until the next start.
- R10: After the last slot of bus 0 (device 31) has been handled with the stack empty, done is 1 for exactly one cycle. bus_count then equals the number of bus numbers assigned and holds until the next done.
- R11: A configuration request holds its valid and all its fields stable until cfg_req_ready is seen, and one response is awaited before the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (taken only when idle) |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | Configuration request accepted |
| cfg_req_bus | output | BUS_W | Target bus number |
| cfg_req_dev | output | DEV_W | Target device number |
| cfg_req_fn | output | FN_W | Target function number |
| cfg_req_reg | output | REG_W | Target dword index in the configuration header |
| cfg_req_wr | output | 1 | 1 for a write, 0 for a read |
| cfg_req_wdata | output | 32 | Write data |
| cfg_rsp_valid | input | 1 | Response valid (one per accepted request) |
| cfg_rsp_data | input | 32 | Read data (ignored for writes) |
| res_valid | output | 1 | Result beat valid |
| res_ready | input | 1 | Result beat accepted |
| res_bus | output | BUS_W | Bus of the reported function |
| res_dev | output | DEV_W | Device of the reported function |
| res_fn | output | FN_W | Function number of the reported function |
| res_vendor | output | 16 | Vendor identifier |
| res_htype | output | 8 | Header type byte |
| done | output | 1 | One-cycle pulse at scan end |
| bus_count | output | BUS_W | Bus numbers assigned during the last scan |
| stack_err | output | 1 | Sticky flag: a subtree was skipped for lack of stack depth |

## Verification
The assertions assume the following about the configuration port:
- A response arrives only after a request has been accepted, exactly once per request, and never in the cycle of acceptance.
- A bus that no bridge has been given reads as all ones.
- The tree needs fewer bus numbers than BUS_W can express.

The bench's responder follows these rules. It takes a new request only when it has no response pending. It answers after a latency of zero to two idle cycles. It maps bus numbers to its modelled buses only through the bridge writes it observes. Its trees are small enough that the bus counter can never wrap.

// File: rtl/walk_pkg.sv
// Package: shared constants and state types for the bus enumeration walker.
// Assumes the configuration header layout in which dword 0 holds the
// identifiers, dword 2 the class code, dword 3 the header type byte and
// dword 6 the bus numbering of a bridge.
package walk_pkg;

    localparam int unsigned DW_ID     = 0;
    localparam int unsigned DW_CLASS  = 2;
    localparam int unsigned DW_HDR    = 3;
    localparam int unsigned DW_BUSNUM = 6;

    localparam logic [23:0] CLASS_CFG_BRIDGE = 24'h060400;
    localparam logic [6:0]  LAYOUT_BRIDGE    = 7'd1;
    localparam logic [31:0] SLOT_EMPTY       = 32'hFFFF_FFFF;
    localparam logic [7:0]  SUB_BUS_OPEN     = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_EMIT,
        ST_NEXT,
        ST_DONE
    } walk_st_t;

    typedef enum logic [1:0] {
        OP_ID,
        OP_HDR,
        OP_CLS,
        OP_BUS
    } cfg_op_t;

endpackage

// File: rtl/walk_stack.sv
// Module: LIFO of saved scan positions.
// Holds one packed entry per level of descent. Push and pop are ignored
// when full or empty respectively. The parent is expected never to request
// either one in that case, and the assertions below check it.
module walk_stack #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned EW    = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [EW-1:0] din,
    output logic [EW-1:0] dout,
    output logic          full,
    output logic          empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned PW = $clog2(DEPTH + 1);

    logic [EW-1:0] mem [DEPTH];
    logic [PW-1:0] sp;
    logic [AW-1:0] wr_idx;
    logic [AW-1:0] top_idx;

    assign full    = (sp == PW'(DEPTH));
    assign empty   = (sp == '0);
    assign wr_idx  = AW'(sp);
    assign top_idx = AW'(sp - PW'(1));
    assign dout    = mem[top_idx];

    // Track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (push && !full) begin
            sp <= sp + PW'(1);
        end else if (pop && !empty) begin
            sp <= sp - PW'(1);
        end
    end

    // Store a pushed entry at the current top.
    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[wr_idx] <= din;
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/walk_cursor.sv
// Module: next-slot computation on one bus.
// From the current device/function and the multi-function flag of the
// device, gives the next slot to probe, or flags that the bus is exhausted.
// Assumes that the flag is cleared when function 0 is absent.
module walk_cursor #(
    parameter int unsigned DEV_W = 5,
    parameter int unsigned FN_W  = 3
) (
    input  logic [DEV_W-1:0] dev,
    input  logic [FN_W-1:0]  fn,
    input  logic             multi,
    output logic [DEV_W-1:0] nxt_dev,
    output logic [FN_W-1:0]  nxt_fn,
    output logic             bus_end
);
    // Step to the next function, else the next device, else end of bus.
    always_comb begin
        nxt_dev = dev;
        nxt_fn  = '0;
        bus_end = 1'b0;
        if (multi && (fn != '1)) begin
            nxt_fn = fn + FN_W'(1);
        end else if (dev == '1) begin
            bus_end = 1'b1;
        end else begin
            nxt_dev = dev + DEV_W'(1);
        end
    end

endmodule

// File: rtl/bus_enum_walker.sv
// Module: depth-first enumeration of a configuration bus tree.
// Probes every slot of bus 0, numbers each bridge it finds with the next
// free bus number and scans behind it before resuming the parent bus.
// Assumes one response per accepted request and that unassigned buses read
// as all ones. BUS_W must not exceed 8 (bus fields of the numbering dword).
module bus_enum_walker
    import walk_pkg::*;
#(
    parameter int unsigned BUS_W       = 8,
    parameter int unsigned DEV_W       = 5,
    parameter int unsigned FN_W        = 3,
    parameter int unsigned REG_W       = 6,
    parameter int unsigned STACK_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             cfg_req_valid,
    input  logic             cfg_req_ready,
    output logic [BUS_W-1:0] cfg_req_bus,
    output logic [DEV_W-1:0] cfg_req_dev,
    output logic [FN_W-1:0]  cfg_req_fn,
    output logic [REG_W-1:0] cfg_req_reg,
    output logic             cfg_req_wr,
    output logic [31:0]      cfg_req_wdata,
    input  logic             cfg_rsp_valid,
    input  logic [31:0]      cfg_rsp_data,
    output logic             res_valid,
    input  logic             res_ready,
    output logic [BUS_W-1:0] res_bus,
    output logic [DEV_W-1:0] res_dev,
    output logic [FN_W-1:0]  res_fn,
    output logic [15:0]      res_vendor,
    output logic [7:0]       res_htype,
    output logic             done,
    output logic [BUS_W-1:0] bus_count,
    output logic             stack_err
);
    localparam int unsigned EW = BUS_W + DEV_W + FN_W + 1;

    walk_st_t         state;
    cfg_op_t          op;
    logic [BUS_W-1:0] bus_q;
    logic [DEV_W-1:0] dev_q;
    logic [FN_W-1:0]  fn_q;
    logic             multi_q;
    logic [15:0]      vendor_q;
    logic [7:0]       htype_q;
    logic [23:0]      class_q;
    logic [BUS_W-1:0] nbus_q;
    logic [BUS_W-1:0] cnt_q;
    logic             err_q;

    logic             is_bridge;
    logic             rsp_take;
    logic             stk_push;
    logic             stk_pop;
    logic             stk_full;
    logic             stk_empty;
    logic [EW-1:0]    stk_din;
    logic [EW-1:0]    stk_dout;
    logic [DEV_W-1:0] nxt_dev;
    logic [FN_W-1:0]  nxt_fn;
    logic             bus_end;

    // Classify the function just read as a bridge to a configuration bus.
    assign is_bridge = (htype_q[6:0] == LAYOUT_BRIDGE) && (class_q == CLASS_CFG_BRIDGE);
    assign rsp_take  = (state == ST_WAIT) && cfg_rsp_valid;
    assign stk_push  = rsp_take && (op == OP_BUS);
    assign stk_pop   = (state == ST_NEXT) && bus_end && !stk_empty;
    assign stk_din   = {bus_q, dev_q, fn_q, multi_q};

    walk_stack #(
        .DEPTH (STACK_DEPTH),
        .EW    (EW)
    ) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (stk_push),
        .pop   (stk_pop),
        .din   (stk_din),
        .dout  (stk_dout),
        .full  (stk_full),
        .empty (stk_empty)
    );

    walk_cursor #(
        .DEV_W (DEV_W),
        .FN_W  (FN_W)
    ) u_cursor (
        .dev     (dev_q),
        .fn      (fn_q),
        .multi   (multi_q),
        .nxt_dev (nxt_dev),
        .nxt_fn  (nxt_fn),
        .bus_end (bus_end)
    );

    // Drive the configuration request from the current slot and operation.
    always_comb begin
        cfg_req_valid = (state == ST_REQ);
        cfg_req_bus   = bus_q;
        cfg_req_dev   = dev_q;
        cfg_req_fn    = fn_q;
        cfg_req_wr    = (op == OP_BUS);
        cfg_req_wdata = {8'h00, SUB_BUS_OPEN, 8'(nbus_q), 8'(bus_q)};
        unique case (op)
            OP_ID:   cfg_req_reg = REG_W'(DW_ID);
            OP_HDR:  cfg_req_reg = REG_W'(DW_HDR);
            OP_CLS:  cfg_req_reg = REG_W'(DW_CLASS);
            default: cfg_req_reg = REG_W'(DW_BUSNUM);
        endcase
    end

    // Present the result beat of the function just read.
    assign res_valid  = (state == ST_EMIT);
    assign res_bus    = bus_q;
    assign res_dev    = dev_q;
    assign res_fn     = fn_q;
    assign res_vendor = vendor_q;
    assign res_htype  = htype_q;
    assign done       = (state == ST_DONE);
    assign bus_count  = cnt_q;
    assign stack_err  = err_q;

    // Walk state machine: probe, read, report, descend, advance, return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op       <= OP_ID;
            bus_q    <= '0;
            dev_q    <= '0;
            fn_q     <= '0;
            multi_q  <= 1'b0;
            vendor_q <= '0;
            htype_q  <= '0;
            class_q  <= '0;
            nbus_q   <= BUS_W'(1);
            cnt_q    <= '0;
            err_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        bus_q   <= '0;
                        dev_q   <= '0;
                        fn_q    <= '0;
                        multi_q <= 1'b0;
                        nbus_q  <= BUS_W'(1);
                        err_q   <= 1'b0;
                        op      <= OP_ID;
                        state   <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (cfg_req_ready) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (cfg_rsp_valid) begin
                        unique case (op)
                            OP_ID: begin
                                if (cfg_rsp_data == SLOT_EMPTY) begin
                                    if (fn_q == '0) begin
                                        multi_q <= 1'b0;
                                    end
                                    state <= ST_NEXT;
                                end else begin
                                    vendor_q <= cfg_rsp_data[15:0];
                                    op       <= OP_HDR;
                                    state    <= ST_REQ;
                                end
                            end
                            OP_HDR: begin
                                htype_q <= cfg_rsp_data[23:16];
                                if (fn_q == '0) begin
                                    multi_q <= cfg_rsp_data[23];
                                end
                                op    <= OP_CLS;
                                state <= ST_REQ;
                            end
                            OP_CLS: begin
                                class_q <= cfg_rsp_data[31:8];
                                state   <= ST_EMIT;
                            end
                            default: begin
                                bus_q   <= nbus_q;
                                nbus_q  <= nbus_q + BUS_W'(1);
                                dev_q   <= '0;
                                fn_q    <= '0;
                                multi_q <= 1'b0;
                                op      <= OP_ID;
                                state   <= ST_REQ;
                            end
                        endcase
                    end
                end
                ST_EMIT: begin
                    if (res_ready) begin
                        if (is_bridge && !stk_full) begin
                            op    <= OP_BUS;
                            state <= ST_REQ;
                        end else begin
                            if (is_bridge) begin
                                err_q <= 1'b1;
                            end
                            state <= ST_NEXT;
                        end
                    end
                end
                ST_NEXT: begin
                    if (bus_end) begin
                        if (stk_empty) begin
                            cnt_q <= nbus_q - BUS_W'(1);
                            state <= ST_DONE;
                        end else begin
                            {bus_q, dev_q, fn_q, multi_q} <= stk_dout;
                        end
                    end else begin
                        dev_q <= nxt_dev;
                        fn_q  <= nxt_fn;
                        op    <= OP_ID;
                        state <= ST_REQ;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req_valid && !cfg_req_ready) |=> (cfg_req_valid &&
            $stable({cfg_req_bus, cfg_req_dev, cfg_req_fn, cfg_req_reg, cfg_req_wr, cfg_req_wdata})));

    // R11
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req_valid && cfg_req_ready) |=> !cfg_req_valid);

    // R5
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid &&
            $stable({res_bus, res_dev, res_fn, res_vendor, res_htype})));

    // R2
    bus_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> (cfg_req_bus < nbus_q));

    // R7
    bus_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req_valid && cfg_req_wr) |-> (cfg_req_wdata[15:8] > cfg_req_wdata[7:0]));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_err && !(state == ST_IDLE && start)) |=> stack_err);

endmodule

// File: tb/bus_enum_walker_tb.sv
module bus_enum_walker_tb;
    localparam int unsigned BUS_W = 8;
    localparam int unsigned DEV_W = 5;
    localparam int unsigned FN_W  = 3;
    localparam int unsigned REG_W = 6;

    typedef struct packed {
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic [15:0] vendor;
        logic [7:0]  htype;
    } res_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             cfg_req_valid;
    logic             cfg_req_ready = 1'b0;
    logic [BUS_W-1:0] cfg_req_bus;
    logic [DEV_W-1:0] cfg_req_dev;
    logic [FN_W-1:0]  cfg_req_fn;
    logic [REG_W-1:0] cfg_req_reg;
    logic             cfg_req_wr;
    logic [31:0]      cfg_req_wdata;
    logic             cfg_rsp_valid = 1'b0;
    logic [31:0]      cfg_rsp_data = '0;
    logic             res_valid;
    logic             res_ready = 1'b0;
    logic [BUS_W-1:0] res_bus;
    logic [DEV_W-1:0] res_dev;
    logic [FN_W-1:0]  res_fn;
    logic [15:0]      res_vendor;
    logic [7:0]       res_htype;
    logic             done;
    logic [BUS_W-1:0] bus_count;
    logic             stack_err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int scn = 0;
    int stall_res = 0;
    int l2p [256];
    res_t exp_res [$];
    logic [31:0] exp_wr [$];
    bit first_req_seen = 0;
    bit pend = 0;
    int lat = 0;
    logic [31:0] pend_data = '0;

    bus_enum_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
        .cfg_req_bus(cfg_req_bus), .cfg_req_dev(cfg_req_dev), .cfg_req_fn(cfg_req_fn),
        .cfg_req_reg(cfg_req_reg), .cfg_req_wr(cfg_req_wr), .cfg_req_wdata(cfg_req_wdata),
        .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_data(cfg_rsp_data),
        .res_valid(res_valid), .res_ready(res_ready),
        .res_bus(res_bus), .res_dev(res_dev), .res_fn(res_fn),
        .res_vendor(res_vendor), .res_htype(res_htype),
        .done(done), .bus_count(bus_count), .stack_err(stack_err)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Modelled topology: physical bus, device, function -> contents.
    function automatic void model(input int pb, input int d, input int f, output bit pr,
                                  output logic [15:0] v, output logic [7:0] h,
                                  output logic [23:0] c, output int ch);
        pr = 1; h = 8'h00; c = 24'h020000; ch = -1; v = 16'h0;
        if (scn == 1) begin
            case ({pb[7:0], d[7:0], f[7:0]})
                24'h00_00_00: begin v = 16'h1111; h = 8'h80; end
                24'h00_00_02: v = 16'h1112;
                24'h00_02_00: begin v = 16'hB000; h = 8'h01; c = 24'h060400; ch = 1; end
                24'h00_03_00: v = 16'h1303;
                24'h00_03_01: v = 16'h1313;
                24'h00_05_00: begin v = 16'h1505; h = 8'h02; c = 24'h060700; end
                24'h00_06_00: begin v = 16'h1606; h = 8'h01; c = 24'h060900; end
                24'h00_1F_00: begin v = 16'h1F00; h = 8'h80; end
                24'h00_1F_07: v = 16'h1F07;
                24'h01_01_00: v = 16'h2101;
                24'h01_04_00: begin v = 16'hB001; h = 8'h01; c = 24'h060400; ch = 2; end
                24'h02_00_00: v = 16'h3000;
                default: pr = 0;
            endcase
        end else begin
            if (d == 0 && f == 0 && pb <= 8) begin
                v = 16'hC000 + 16'(pb); h = 8'h01; c = 24'h060400; ch = pb + 1;
            end else if (d == 0 && f == 0 && pb == 9) begin
                v = 16'h9999;
            end else begin
                pr = 0;
            end
        end
    endfunction

    // Configuration responder: accepts one request, answers after a latency.
    always @(negedge clk) begin
        bit pr; logic [15:0] v; logic [7:0] h; logic [23:0] c; int ch; int pb;
        cyc++;
        cfg_rsp_valid = 1'b0;
        cfg_req_ready = 1'b0;
        if (pend) begin
            if (lat == 0) begin
                cfg_rsp_valid = 1'b1;
                cfg_rsp_data  = pend_data;
                pend = 0;
            end else begin
                lat--;
            end
        end else if (cfg_req_valid && (cyc % 4 != 1)) begin
            cfg_req_ready = 1'b1;
            pend = 1;
            lat = cyc % 3;
            pb = l2p[cfg_req_bus];
            if (!first_req_seen) begin
                first_req_seen = 1;
                chk(cfg_req_bus == 0 && cfg_req_dev == 0 && cfg_req_fn == 0 && cfg_req_reg == 0 && !cfg_req_wr,
                    "R2 first request", {cfg_req_bus, cfg_req_dev, cfg_req_fn, cfg_req_reg}, 64'h0);
            end
            if (pb < 0) begin
                pr = 0; v = '0; h = '0; c = '0; ch = -1;
            end else begin
                model(pb, int'(cfg_req_dev), int'(cfg_req_fn), pr, v, h, c, ch);
            end
            if (cfg_req_wr) begin
                pend_data = '0;
                if (exp_wr.size() == 0) begin
                    chk(0, "R6/R8/R9 unexpected bridge write", cfg_req_wdata, 0);
                end else begin
                    logic [31:0] e;
                    e = exp_wr.pop_front();
                    chk(cfg_req_wdata == e && cfg_req_reg == 6, "R6/R7 bridge bus write", cfg_req_wdata, e);
                end
                if (pr && cfg_req_wdata[15:8] != 0) l2p[cfg_req_wdata[15:8]] = ch;
            end else if (!pr) begin
                pend_data = 32'hFFFF_FFFF;
            end else begin
                case (cfg_req_reg)
                    6'd0: pend_data = {16'hD000, v};
                    6'd2: pend_data = {c, 8'h01};
                    6'd3: pend_data = {8'h00, h, 8'h00, 8'h10};
                    default: pend_data = '0;
                endcase
            end
        end
    end

    // Result monitor: pops the scoreboard for each beat accepted.
    always @(negedge clk) begin
        res_ready = (stall_res != 0) ? (cyc % 3 != 0) : 1'b1;
        if (res_valid && res_ready) begin
            if (exp_res.size() == 0) begin
                chk(0, "R3/R4/R5 unexpected result", {res_bus, res_dev, res_fn, res_vendor, res_htype}, 0);
            end else begin
                res_t e;
                res_t a;
                e = exp_res.pop_front();
                a = '{bus: res_bus, dev: res_dev, fn: res_fn, vendor: res_vendor, htype: res_htype};
                chk(a == e, "R5 result beat", a, e);
            end
        end
    end

    task automatic push_res(input int b, input int d, input int f, input logic [15:0] v, input logic [7:0] h);
        exp_res.push_back('{bus: 8'(b), dev: 5'(d), fn: 3'(f), vendor: v, htype: h});
    endtask

    task automatic run_scan(input int s, input int stall, input logic [7:0] exp_cnt, input bit exp_err);
        bit seen;
        scn = s;
        stall_res = stall;
        for (int i = 0; i < 256; i++) l2p[i] = -1;
        l2p[0] = 0;
        first_req_seen = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            @(negedge clk);
            if (done) begin
                seen = 1;
                chk(bus_count == exp_cnt, "R7/R10 bus count", bus_count, exp_cnt);
                chk(stack_err == exp_err, "R9 stack error flag", stack_err, exp_err);
                chk(exp_res.size() == 0, "R3/R4/R5 missing results", exp_res.size(), 0);
                chk(exp_wr.size() == 0, "R6 missing bridge writes", exp_wr.size(), 0);
            end
        end
        chk(seen, "R10 done never seen", 0, 1);
        @(negedge clk);
        chk(!done && bus_count == exp_cnt, "R10 done one cycle, count held", {done, bus_count}, {1'b0, exp_cnt});
    endtask

    task automatic load_tree;
        push_res(0, 0, 0, 16'h1111, 8'h80);
        push_res(0, 0, 2, 16'h1112, 8'h00);   // R3: fn1 absent, fn2 still probed
        push_res(0, 2, 0, 16'hB000, 8'h01);   // R6: bridge, bus 1
        push_res(1, 1, 0, 16'h2101, 8'h00);
        push_res(1, 4, 0, 16'hB001, 8'h01);   // R7: second bridge, bus 2
        push_res(2, 0, 0, 16'h3000, 8'h00);
        push_res(0, 3, 0, 16'h1303, 8'h00);   // R4: fn1 of dev3 not probed
        push_res(0, 5, 0, 16'h1505, 8'h02);   // R8: cardbus layout
        push_res(0, 6, 0, 16'h1606, 8'h01);   // R8: layout 1 with other class
        push_res(0, 31, 0, 16'h1F00, 8'h80);
        push_res(0, 31, 7, 16'h1F07, 8'h00);  // R4: last function of last device
        exp_wr.push_back(32'h00FF_0100);
        exp_wr.push_back(32'h00FF_0201);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: idle after reset
        chk(!cfg_req_valid && !res_valid && !done && !stack_err, "R1 reset state",
            {cfg_req_valid, res_valid, done, stack_err}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!cfg_req_valid && !res_valid, "R1 nothing before start", {cfg_req_valid, res_valid}, 0);

        load_tree();
        run_scan(1, 1, 8'd2, 1'b0);

        // R9: chain of nine bridges, the ninth overflows the stack
        for (int k = 0; k <= 8; k++) push_res(k, 0, 0, 16'hC000 + 16'(k), 8'h01);
        for (int k = 0; k < 8; k++) exp_wr.push_back({8'h00, 8'hFF, 8'(k + 1), 8'(k)});
        run_scan(2, 0, 8'd8, 1'b1);

        // R9: a fresh start clears the flag
        load_tree();
        run_scan(1, 0, 8'd2, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule